// File: doc/BRIEF.md
# SERDES receiver reset sequencer

This block brings a multi-channel source-synchronous deserializer with dynamic phase alignment out of reset in a fixed order. It runs on a free-running reference clock that does not depend on the receiver PLL, so it keeps working while that PLL is held in reset. It drives the PLL reset, a per-channel phase-alignment reset and a per-channel alignment-FIFO reset. It also drives a ready flag and an active-low core reset for the logic downstream.

Its inputs are an active-low external reset, the PLL lock flag and a per-channel alignment-lock vector. Both lock inputs are asynchronous, so each one passes through a two-flop synchronizer before the state machine uses it. Every reset output comes from its own register. The sequence starts by holding everything in reset. It then releases the PLL, waits until the PLL lock has stayed high for a programmable time, and releases phase alignment. Once every channel reports alignment lock, it keeps the FIFO reset on for a programmable pulse and then declares the link ready. If alignment is lost, the FIFOs are reset again. If the PLL lock is lost, the whole sequence restarts.

The states are `ST_RESET`, `ST_PLL_WAIT`, `ST_ALIGN_WAIT`, `ST_FIFO_PULSE` and `ST_RUN`. The transitions are:
- `ST_RESET` to `ST_PLL_WAIT` when the hold time ends.
- `ST_PLL_WAIT` to `ST_ALIGN_WAIT` when the lock has been stable for the required time.
- `ST_ALIGN_WAIT` to `ST_FIFO_PULSE` when every channel is locked.
- `ST_FIFO_PULSE` to `ST_RUN` when the pulse time ends.
- `ST_FIFO_PULSE` or `ST_RUN` back to `ST_ALIGN_WAIT` when any channel loses alignment lock.
- `ST_ALIGN_WAIT`, `ST_FIFO_PULSE` or `ST_RUN` back to `ST_RESET` when the synchronized PLL lock goes low.

Top module: `rxrst_sequencer`

## Requirements
- R1: While `rst_n_ext` is low, the outputs are `pll_rst`=1, every `align_rst` bit 1, every `fifo_rst` bit 1, `ready`=0 and `core_rst_n`=0. These values appear asynchronously.
- R2: If `rst_n_ext` goes high before clock edge N+1, `pll_rst` stays high through edge N+PLL_RST_CYC-1 and falls at edge N+PLL_RST_CYC. `align_rst` and `fifo_rst` stay high at that point.
- R3: `align_rst` falls only after the synchronized PLL lock has been high for LOCK_STABLE_CYC consecutive cycles. Suppose `pll_lock_in` rises before edge N+1 and stays high. Then `align_rst` stays high through edge N+LOCK_STABLE_CYC+1 and falls at edge N+LOCK_STABLE_CYC+2. Any low cycle of the lock during the count restarts the count.
- R4: Both lock inputs pass through two flops. A change that is sampled at edge N+1 cannot affect any output before edge N+3.
- R5: Suppose all alignment-lock bits are high from before edge N+1 and the sequencer is in `ST_ALIGN_WAIT`. Then `fifo_rst` stays high through edge N+FIFO_PULSE_CYC+2. At edge N+FIFO_PULSE_CYC+3, `fifo_rst` goes to all zeros and `ready`=1 and `core_rst_n`=1 on that same edge.
- R6: `fifo_rst` is asserted on all channels together whenever any alignment-lock bit is low. With only some channels locked, `fifo_rst` stays all ones and `ready` stays 0.
- R7: If an alignment lock drops during the FIFO pulse, `ready` is not asserted. After every channel is locked again, a complete new pulse of FIFO_PULSE_CYC cycles is applied before `ready` rises.
- R8: If an alignment-lock bit drops before edge N+1 while the sequencer is in `ST_RUN`, then at edge N+3 `ready` and `core_rst_n` go to 0 and `fifo_rst` goes to all ones, while `align_rst` stays at 0.
- R9: Suppose the PLL lock drops before edge N+1 in `ST_ALIGN_WAIT`, `ST_FIFO_PULSE` or `ST_RUN`. Then at edge N+3 the R1 values return. `pll_rst` falls again at edge N+3+PLL_RST_CYC, and the full sequence repeats.
- R10: `align_rst` is never low while `pll_rst` is high. `ready` is never high while any reset output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n_ext | input | 1 | External reset, active low, asynchronous assert |
| pll_lock_in | input | 1 | Receiver PLL lock flag, asynchronous |
| align_lock_in | input | NUM_CH | Per-channel phase-alignment lock, asynchronous |
| pll_rst | output | 1 | PLL reset, active high, registered |
| align_rst | output | NUM_CH | Per-channel phase-alignment reset, registered |
| fifo_rst | output | NUM_CH | Per-channel alignment-FIFO reset, registered |
| ready | output | 1 | Link up, all resets released |
| core_rst_n | output | 1 | Downstream core reset, active low |

## Verification
The bench aims at the exact edge on which each reset output changes, both before and after the change. A missing synchronizer stage, or an off-by-one in the hold, stable or pulse count, then shows up as an early or late transition. It breaks the PLL lock in the middle of the stable count: a design that does not restart the count would release alignment reset too early. It drops a channel's lock partway through the FIFO pulse: a design that finishes the pulse anyway would raise `ready` while a channel is unlocked. It removes the PLL lock while the link is running: a design that does not fold lock loss back into the reset state would leave alignment running on a dead clock.

// File: rtl/rxrst_pkg.sv
package rxrst_pkg;

    typedef enum logic [2:0] {
        ST_RESET      = 3'd0,
        ST_PLL_WAIT   = 3'd1,
        ST_ALIGN_WAIT = 3'd2,
        ST_FIFO_PULSE = 3'd3,
        ST_RUN        = 3'd4
    } rxrst_state_e;

endpackage

// File: rtl/rxrst_sync2.sv
module rxrst_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end

endmodule

// File: rtl/rxrst_run_timer.sv
module rxrst_run_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic qual,
    output logic done
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST);
    assign done    = en && qual && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || !qual || at_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);                                        // R3

    AST_TIMER_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || !qual) |=> (cnt_q == '0));                     // R5

endmodule

// File: rtl/rxrst_sequencer.sv
module rxrst_sequencer
    import rxrst_pkg::*;
#(
    parameter int NUM_CH          = 16,
    parameter int PLL_RST_CYC     = 8,
    parameter int LOCK_STABLE_CYC = 256,
    parameter int FIFO_PULSE_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n_ext,
    input  logic              pll_lock_in,
    input  logic [NUM_CH-1:0] align_lock_in,
    output logic              pll_rst,
    output logic [NUM_CH-1:0] align_rst,
    output logic [NUM_CH-1:0] fifo_rst,
    output logic              ready,
    output logic              core_rst_n
);

    localparam int SYNC_W = NUM_CH + 1;

    rxrst_state_e state_q, state_d;
    logic [SYNC_W-1:0] lock_raw, lock_s;
    logic        pll_lock_s;
    logic [NUM_CH-1:0] align_lock_s;
    logic        all_locked;
    logic        hold_done, stable_done, pulse_done;
    logic        align_rst_d, fifo_rst_d;

    assign lock_raw = {pll_lock_in, align_lock_in};

    rxrst_sync2 #(.WIDTH(SYNC_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n_ext),
        .async_in (lock_raw),
        .sync_out (lock_s)
    );

    assign pll_lock_s   = lock_s[SYNC_W-1];
    assign align_lock_s = lock_s[NUM_CH-1:0];
    assign all_locked   = &align_lock_s;

    rxrst_run_timer #(.LIMIT(PLL_RST_CYC)) u_hold_timer (
        .clk   (clk),
        .rst_n (rst_n_ext),
        .en    (state_q == ST_RESET),
        .qual  (1'b1),
        .done  (hold_done)
    );

    rxrst_run_timer #(.LIMIT(LOCK_STABLE_CYC)) u_stable_timer (
        .clk   (clk),
        .rst_n (rst_n_ext),
        .en    (state_q == ST_PLL_WAIT),
        .qual  (pll_lock_s),
        .done  (stable_done)
    );

    rxrst_run_timer #(.LIMIT(FIFO_PULSE_CYC)) u_pulse_timer (
        .clk   (clk),
        .rst_n (rst_n_ext),
        .en    (state_q == ST_FIFO_PULSE),
        .qual  (1'b1),
        .done  (pulse_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET: begin
                if (hold_done) state_d = ST_PLL_WAIT;
            end
            ST_PLL_WAIT: begin
                if (stable_done) state_d = ST_ALIGN_WAIT;
            end
            ST_ALIGN_WAIT: begin
                if (!pll_lock_s)     state_d = ST_RESET;
                else if (all_locked) state_d = ST_FIFO_PULSE;
            end
            ST_FIFO_PULSE: begin
                if (!pll_lock_s)      state_d = ST_RESET;
                else if (!all_locked) state_d = ST_ALIGN_WAIT;
                else if (pulse_done)  state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!pll_lock_s)      state_d = ST_RESET;
                else if (!all_locked) state_d = ST_ALIGN_WAIT;
            end
            default: state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n_ext) begin
        if (!rst_n_ext) state_q <= ST_RESET;
        else            state_q <= state_d;
    end

    assign align_rst_d = (state_d == ST_RESET) || (state_d == ST_PLL_WAIT);
    assign fifo_rst_d  = (state_d != ST_RUN);

    always_ff @(posedge clk or negedge rst_n_ext) begin
        if (!rst_n_ext) begin
            pll_rst    <= 1'b1;
            ready      <= 1'b0;
            core_rst_n <= 1'b0;
        end else begin
            pll_rst    <= (state_d == ST_RESET);
            ready      <= (state_d == ST_RUN);
            core_rst_n <= (state_d == ST_RUN);
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane_rst
        always_ff @(posedge clk or negedge rst_n_ext) begin
            if (!rst_n_ext) begin
                align_rst[ch] <= 1'b1;
                fifo_rst[ch]  <= 1'b1;
            end else begin
                align_rst[ch] <= align_rst_d;
                fifo_rst[ch]  <= fifo_rst_d;
            end
        end
    end

    AST_ALIGN_BEHIND_PLL: assert property (@(posedge clk) disable iff (!rst_n_ext)
        !align_rst[0] |-> !pll_rst);                                       // R10

    AST_READY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n_ext)
        ready |-> (!pll_rst && align_rst == '0 && fifo_rst == '0 && core_rst_n)); // R10

    AST_ALIGN_RELEASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n_ext)
        $fell(align_rst[0]) |-> $past(pll_lock_s));                        // R3

    AST_READY_ALL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n_ext)
        $rose(ready) |-> $past(all_locked));                               // R5

    AST_PLL_LOSS_RESTART: assert property (@(posedge clk) disable iff (!rst_n_ext)
        ((state_q == ST_ALIGN_WAIT || state_q == ST_FIFO_PULSE || state_q == ST_RUN)
         && !pll_lock_s) |=> (pll_rst && align_rst == '1));                // R9

    AST_LOCK_LOSS_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n_ext)
        (state_q == ST_RUN && pll_lock_s && !all_locked)
        |=> (!ready && fifo_rst == '1 && align_rst == '0));               // R8

endmodule

// File: tb/rxrst_sequencer_test.sv
module rxrst_sequencer_test;

    localparam int NCH = 4;
    localparam int H   = 2;
    localparam int S   = 8;
    localparam int P   = 3;
    localparam int W   = 3 + 2 * NCH;

    typedef struct {
        int           at;
        logic [W-1:0] v;
        string        tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n_ext;
    logic           pll_lock_in;
    logic [NCH-1:0] align_lock_in;
    logic           pll_rst;
    logic [NCH-1:0] align_rst;
    logic [NCH-1:0] fifo_rst;
    logic           ready;
    logic           core_rst_n;

    exp_t sb[$];
    int   cyc = 0;
    int   vectors = 0;
    int   miscompares = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    rxrst_sequencer #(
        .NUM_CH          (NCH),
        .PLL_RST_CYC     (H),
        .LOCK_STABLE_CYC (S),
        .FIFO_PULSE_CYC  (P)
    ) uut (
        .clk           (clk),
        .rst_n_ext     (rst_n_ext),
        .pll_lock_in   (pll_lock_in),
        .align_lock_in (align_lock_in),
        .pll_rst       (pll_rst),
        .align_rst     (align_rst),
        .fifo_rst      (fifo_rst),
        .ready         (ready),
        .core_rst_n    (core_rst_n)
    );

    function automatic logic [W-1:0] mk(bit pr, bit ar, bit fr, bit rdy);
        return {pr, {NCH{ar}}, {NCH{fr}}, rdy, rdy};
    endfunction

    task automatic push(int at, logic [W-1:0] v, string tag);
        exp_t e;
        e.at = at; e.v = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    // monitor: samples 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #1;
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                exp_t e;
                logic [W-1:0] act;
                e   = sb.pop_front();
                act = {pll_rst, align_rst, fifo_rst, ready, core_rst_n};
                vectors++;
                if (e.at < cyc) begin
                    miscompares++;
                    $display("FAIL %s: cycle %0d not sampled, actual %b expected %b",
                             e.tag, e.at, act, e.v);
                end else if (act !== e.v) begin
                    miscompares++;
                    $display("FAIL %s @cyc %0d: actual %b expected %b",
                             e.tag, cyc, act, e.v);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog (all R): actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int c, m;
        rst_n_ext     = 1'b0;
        pll_lock_in   = 1'b0;
        align_lock_in = '0;
        @(negedge clk);

        // R1: reset values
        c = cyc;
        push(c + 1, mk(1, 1, 1, 0), "R1 reset");
        push(c + 3, mk(1, 1, 1, 0), "R1 reset held");
        wait_until(c + 4);

        // R2: PLL reset hold
        c = cyc;
        rst_n_ext = 1'b1;
        push(c + H - 1, mk(1, 1, 1, 0), "R2 pll held");
        push(c + H,     mk(0, 1, 1, 0), "R2 pll release");
        push(c + H + 15, mk(0, 1, 1, 0), "R3 no lock keeps align");
        wait_until(c + H + 15);

        // R3: glitch restarts stable count
        c = cyc;
        pll_lock_in = 1'b1;
        wait_until(c + 4);
        pll_lock_in = 1'b0;
        wait_until(c + 6);
        pll_lock_in = 1'b1;
        m = cyc;
        push(c + S + 2, mk(0, 1, 1, 0), "R3 restart no early release");
        push(m + S + 1, mk(0, 1, 1, 0), "R3 align held");
        push(m + S + 2, mk(0, 0, 1, 0), "R3 align release");
        wait_until(m + S + 2);

        // R6: partial lock
        c = cyc;
        align_lock_in = 4'b0111;
        push(c + 8, mk(0, 0, 1, 0), "R6 partial lock");
        wait_until(c + 8);

        // R5 / R4: full lock, FIFO pulse
        c = cyc;
        align_lock_in = 4'b1111;
        push(c + 2,     mk(0, 0, 1, 0), "R4 sync latency");
        push(c + P + 2, mk(0, 0, 1, 0), "R5 pulse held");
        push(c + P + 3, mk(0, 0, 0, 1), "R5 ready");
        wait_until(c + P + 5);

        // R8: lock loss while running
        c = cyc;
        align_lock_in = 4'b1011;
        push(c + 2, mk(0, 0, 0, 1), "R8 before drop");
        push(c + 3, mk(0, 0, 1, 0), "R8 drop");
        wait_until(c + 6);

        // R7: drop during pulse
        c = cyc;
        align_lock_in = 4'b1111;
        wait_until(c + 1);
        align_lock_in = 4'b1110;
        push(c + 3,     mk(0, 0, 1, 0), "R7 in pulse");
        push(c + P + 3, mk(0, 0, 1, 0), "R7 no ready");
        push(c + P + 6, mk(0, 0, 1, 0), "R7 still waiting");
        wait_until(c + P + 6);
        c = cyc;
        align_lock_in = 4'b1111;
        push(c + P + 2, mk(0, 0, 1, 0), "R7 full pulse held");
        push(c + P + 3, mk(0, 0, 0, 1), "R7 relock ready");
        wait_until(c + P + 5);

        // R9: PLL loss while running
        c = cyc;
        pll_lock_in = 1'b0;
        push(c + 2,         mk(0, 0, 0, 1), "R9 before loss");
        push(c + 3,         mk(1, 1, 1, 0), "R9 back to reset");
        push(c + 3 + H,     mk(0, 1, 1, 0), "R9 pll rerelease");
        wait_until(c + 3 + H + 2);
        c = cyc;
        pll_lock_in = 1'b1;
        push(c + S + 1,     mk(0, 1, 1, 0), "R9 align held");
        push(c + S + 2,     mk(0, 0, 1, 0), "R9 align release");
        push(c + S + P + 2, mk(0, 0, 1, 0), "R9 pulse held");
        push(c + S + P + 3, mk(0, 0, 0, 1), "R9 ready again");
        wait_until(c + S + P + 5);

        // R1: asynchronous reset while running
        c = cyc;
        rst_n_ext = 1'b0;
        push(c + 1, mk(1, 1, 1, 0), "R1 async reset");
        wait_until(c + 2);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule